// File: doc/BRIEF.md
# PCI Configuration Status Register

This block holds the 16-bit status word of a PCI function's configuration header. Single-cycle event pulses from the bus interface logic set six sticky flags. These flags record parity errors, system-error signalling and three kinds of abort. Each flag stays set until software clears it by writing a one to its bit position. The remaining bits are read-only capability and timing fields with fixed values.

Two independent ports reach the register. One is a local internal-bus port and the other is a PCI configuration-space port. Both return the same read image combinationally, and both can clear flags. Each write carries two byte enables: bit 0 enables bits 7:0 and bit 1 enables bits 15:8.

A host-mode input stops every flag from being recorded. The master data parity flag is set only when a qualifying combination of conditions holds in the same cycle.

All access pins are plain control signals. A write is taken on every clock edge where its write strobe is high, and the block never applies back-pressure.

Top module: `pci_cfg_status_reg`

## Requirements
- R1: After reset both read ports return 16'h0210.
- R2: Bits 10:9 always read 2'b01 and bit 4 always reads 1. Bits 7, 6, 5 and 3:0 always read 0. Writes to any of these bits have no effect.
- R3: A pulse on the event input of a sticky flag sets that flag, and the flag reads 1 from the next clock edge onward. The flags are: bit 15 on a detected parity error, bit 14 on system error driven, bit 13 on a received master-abort, bit 12 on a received target-abort, and bit 11 on a signalled target-abort.
- R4: Bit 8 is set only when three conditions hold in the same cycle. The parity-error response enable is 1. The function was bus master. Either the function drove parity error on a read, or it observed parity error on a write.
- R5: Writing 1 to a set sticky bit, with its byte lane enabled, clears it from the next edge. Writing 0 leaves the bit unchanged.
- R6: A clear acts only inside enabled byte lanes. Byte enable bit 1 covers bits 15:8 and byte enable bit 0 covers bits 7:0.
- R7: Either port can clear flags. When both ports write in the same cycle, their clear masks are combined by OR.
- R8: If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: While host_mode is 1, no sticky bit becomes set, but clears still work.
- R10: Both ports always return the same read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | Blocks recording of all events |
| perr_resp_en | input | 1 | Parity-error response control bit |
| ev_parity_det | input | 1 | Parity error detected pulse |
| ev_serr_drv | input | 1 | System error driven pulse |
| ev_mabort_rcv | input | 1 | Master-abort received pulse |
| ev_tabort_rcv | input | 1 | Target-abort received pulse |
| ev_tabort_sig | input | 1 | Target-abort signalled pulse |
| mst_owner | input | 1 | Function was bus master of the errored transfer |
| mst_perr_drv_rd | input | 1 | Function drove parity error on a read |
| mst_perr_obs_wr | input | 1 | Function observed parity error on a write |
| lb_wr_en | input | 1 | Internal-bus write strobe |
| lb_be | input | 2 | Internal-bus byte enables |
| lb_wdata | input | 16 | Internal-bus write data |
| lb_rdata | output | 16 | Internal-bus read data |
| cfg_wr_en | input | 1 | Configuration port write strobe |
| cfg_be | input | 2 | Configuration port byte enables |
| cfg_wdata | input | 16 | Configuration port write data |
| cfg_rdata | output | 16 | Configuration port read data |

## Verification
Each flag holds one register between the pins and the read ports. An event pulse or a write applied in one cycle therefore shows on both read ports after the next rising edge, and the reset value shows as soon as reset has been applied. The bench drives stimulus on a falling edge and removes it on the following falling edge. It samples both read ports at that second falling edge, exactly one rising edge after the stimulus. Fixed bits do not depend on any register, and they are checked within the same sample.

// File: rtl/pcistat_pkg.sv
package pcistat_pkg;
  localparam int STAT_W = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = STAT_W / LANE_W;

  // Bit positions that software decodes.
  localparam int B_DPE  = 15;
  localparam int B_SSE  = 14;
  localparam int B_RMA  = 13;
  localparam int B_RTA  = 12;
  localparam int B_STA  = 11;
  localparam int B_MDPE = 8;

  localparam logic [STAT_W-1:0] STICKY_MASK = 16'hF900;
  localparam logic [STAT_W-1:0] FIXED_VAL   = 16'h0210;
endpackage

// File: rtl/pcistat_mdpe_qual.sv
module pcistat_mdpe_qual (
  input  logic perr_resp_en,
  input  logic mst_owner,
  input  logic mst_perr_drv_rd,
  input  logic mst_perr_obs_wr,
  output logic mdpe_set
);
  logic perr_seen;
  always_comb begin
    perr_seen = mst_perr_drv_rd | mst_perr_obs_wr;
    mdpe_set  = perr_resp_en & mst_owner & perr_seen;
  end
endmodule

// File: rtl/pcistat_clr_merge.sv
module pcistat_clr_merge
  import pcistat_pkg::*;
(
  input  logic              a_wr,
  input  logic [LANES-1:0]  a_be,
  input  logic [STAT_W-1:0] a_data,
  input  logic              b_wr,
  input  logic [LANES-1:0]  b_be,
  input  logic [STAT_W-1:0] b_data,
  output logic [STAT_W-1:0] clr_mask
);
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic a_hit, b_hit;
    assign a_hit = a_wr & a_be[ln];
    assign b_hit = b_wr & b_be[ln];
    assign clr_mask[ln*LANE_W +: LANE_W] =
        (a_hit ? a_data[ln*LANE_W +: LANE_W] : '0) |
        (b_hit ? b_data[ln*LANE_W +: LANE_W] : '0);
  end
endmodule

// File: rtl/pcistat_flag_cell.sv
module pcistat_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic blk,
  output logic q
);
  logic set_ok;
  assign set_ok = set_req & ~blk;

  always_ff @(posedge clk) begin
    if (!rst_n)       q <= 1'b0;
    else if (set_ok)  q <= 1'b1;
    else if (clr_req) q <= 1'b0;
  end
endmodule

// File: rtl/pci_cfg_status_reg.sv
module pci_cfg_status_reg
  import pcistat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_mode,
  input  logic              perr_resp_en,
  input  logic              ev_parity_det,
  input  logic              ev_serr_drv,
  input  logic              ev_mabort_rcv,
  input  logic              ev_tabort_rcv,
  input  logic              ev_tabort_sig,
  input  logic              mst_owner,
  input  logic              mst_perr_drv_rd,
  input  logic              mst_perr_obs_wr,
  input  logic              lb_wr_en,
  input  logic [LANES-1:0]  lb_be,
  input  logic [STAT_W-1:0] lb_wdata,
  output logic [STAT_W-1:0] lb_rdata,
  input  logic              cfg_wr_en,
  input  logic [LANES-1:0]  cfg_be,
  input  logic [STAT_W-1:0] cfg_wdata,
  output logic [STAT_W-1:0] cfg_rdata
);
  logic              mdpe_set;
  logic [STAT_W-1:0] clr_mask;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] image;

  pcistat_mdpe_qual u_qual (
    .perr_resp_en    (perr_resp_en),
    .mst_owner       (mst_owner),
    .mst_perr_drv_rd (mst_perr_drv_rd),
    .mst_perr_obs_wr (mst_perr_obs_wr),
    .mdpe_set        (mdpe_set)
  );

  pcistat_clr_merge u_clr (
    .a_wr     (lb_wr_en),
    .a_be     (lb_be),
    .a_data   (lb_wdata),
    .b_wr     (cfg_wr_en),
    .b_be     (cfg_be),
    .b_data   (cfg_wdata),
    .clr_mask (clr_mask)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_DPE]  = ev_parity_det;
    set_vec[B_SSE]  = ev_serr_drv;
    set_vec[B_RMA]  = ev_mabort_rcv;
    set_vec[B_RTA]  = ev_tabort_rcv;
    set_vec[B_STA]  = ev_tabort_sig;
    set_vec[B_MDPE] = mdpe_set;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_sticky
      pcistat_flag_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_vec[i]),
        .clr_req (clr_mask[i]),
        .blk     (host_mode),
        .q       (image[i])
      );
    end else begin : g_fixed
      assign image[i] = FIXED_VAL[i];
    end
  end

  assign lb_rdata  = image;
  assign cfg_rdata = image;
endmodule

// File: rtl/pcistat_chk.sv
module pcistat_chk
  import pcistat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              host_mode,
  input logic              perr_resp_en,
  input logic              ev_parity_det,
  input logic              ev_serr_drv,
  input logic              ev_mabort_rcv,
  input logic              ev_tabort_rcv,
  input logic              ev_tabort_sig,
  input logic              mst_owner,
  input logic              mst_perr_drv_rd,
  input logic              mst_perr_obs_wr,
  input logic              lb_wr_en,
  input logic [LANES-1:0]  lb_be,
  input logic [STAT_W-1:0] lb_wdata,
  input logic              cfg_wr_en,
  input logic [STAT_W-1:0] lb_rdata,
  input logic [STAT_W-1:0] cfg_rdata
);
  logic any_ev;
  assign any_ev = ev_parity_det | ev_serr_drv | ev_mabort_rcv | ev_tabort_rcv |
                  ev_tabort_sig | mst_perr_drv_rd | mst_perr_obs_wr;

  assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_rdata & ~STICKY_MASK) == FIXED_VAL);

  assert_ports_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lb_rdata == cfg_rdata);

  assert_dpe_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_parity_det && !host_mode) |=> lb_rdata[B_DPE]);

  assert_mdpe_qual_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lb_rdata[B_MDPE] && !(perr_resp_en && mst_owner &&
      (mst_perr_drv_rd || mst_perr_obs_wr))) |=> !lb_rdata[B_MDPE]);

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lb_wr_en && !cfg_wr_en && !any_ev) |=> $stable(lb_rdata));

  assert_lb_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_wr_en && lb_be[1] && lb_wdata[B_DPE] && !ev_parity_det) |=> !lb_rdata[B_DPE]);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mabort_rcv && !host_mode) |=> lb_rdata[B_RMA]);

  assert_host_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_mode |=> ((lb_rdata & ~$past(lb_rdata) & STICKY_MASK) == '0));
endmodule

bind pci_cfg_status_reg pcistat_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .host_mode       (host_mode),
  .perr_resp_en    (perr_resp_en),
  .ev_parity_det   (ev_parity_det),
  .ev_serr_drv     (ev_serr_drv),
  .ev_mabort_rcv   (ev_mabort_rcv),
  .ev_tabort_rcv   (ev_tabort_rcv),
  .ev_tabort_sig   (ev_tabort_sig),
  .mst_owner       (mst_owner),
  .mst_perr_drv_rd (mst_perr_drv_rd),
  .mst_perr_obs_wr (mst_perr_obs_wr),
  .lb_wr_en        (lb_wr_en),
  .lb_be           (lb_be),
  .lb_wdata        (lb_wdata),
  .cfg_wr_en       (cfg_wr_en),
  .lb_rdata        (lb_rdata),
  .cfg_rdata       (cfg_rdata)
);

// File: tb/tb_pci_cfg_status_reg.sv
module tb_pci_cfg_status_reg;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n, host_mode, perr_resp_en;
  logic ev_parity_det, ev_serr_drv, ev_mabort_rcv, ev_tabort_rcv, ev_tabort_sig;
  logic mst_owner, mst_perr_drv_rd, mst_perr_obs_wr;
  logic lb_wr_en, cfg_wr_en;
  logic [1:0] lb_be, cfg_be;
  logic [15:0] lb_wdata, cfg_wdata, lb_rdata, cfg_rdata;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_cfg_status_reg dut (.*);

  task automatic chk(string tag, logic [15:0] exp);
    n_checks++;
    if (lb_rdata !== exp) begin
      n_errors++;
      $display("FAIL %s lb_rdata actual=%h expected=%h", tag, lb_rdata, exp);
    end
    if (cfg_rdata !== exp) begin
      n_errors++;
      $display("FAIL %s/R10 cfg_rdata actual=%h expected=%h", tag, cfg_rdata, exp);
    end
  endtask

  task automatic idle();
    {ev_parity_det, ev_serr_drv, ev_mabort_rcv, ev_tabort_rcv, ev_tabort_sig} = '0;
    {mst_owner, mst_perr_drv_rd, mst_perr_obs_wr} = '0;
    lb_wr_en = 0; cfg_wr_en = 0; lb_be = 0; cfg_be = 0;
    lb_wdata = 0; cfg_wdata = 0;
  endtask

  // Stimulus was applied at a falling edge; pass one rising edge and sample.
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    rst_n = 0; host_mode = 0; perr_resp_en = 0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic lb_clear(logic [1:0] be, logic [15:0] d);
    lb_wr_en = 1; lb_be = be; lb_wdata = d;
  endtask

  task automatic t_reset();
    chk("R1 reset", 16'h0210);
  endtask

  task automatic t_events();
    ev_parity_det = 1; step(); chk("R3 dpe", 16'h8210);
    ev_serr_drv   = 1; step(); chk("R3 sse", 16'hC210);
    ev_mabort_rcv = 1; step(); chk("R3 rma", 16'hE210);
    ev_tabort_rcv = 1; step(); chk("R3 rta", 16'hF210);
    ev_tabort_sig = 1; step(); chk("R3 sta", 16'hFA10);
    step(); chk("R3 sticky", 16'hFA10);
    lb_clear(2'b11, 16'hFFFF); step(); chk("R5 clear all", 16'h0210);
  endtask

  task automatic t_mdpe();
    perr_resp_en = 0; mst_owner = 1; mst_perr_drv_rd = 1; step();
    chk("R4 no resp_en", 16'h0210);
    perr_resp_en = 1; mst_owner = 0; mst_perr_obs_wr = 1; step();
    chk("R4 not master", 16'h0210);
    mst_owner = 1; step();
    chk("R4 no perr", 16'h0210);
    mst_owner = 1; mst_perr_obs_wr = 1; step();
    chk("R4 write path", 16'h0310);
    lb_clear(2'b10, 16'h0100); step(); chk("R5 clear mdpe", 16'h0210);
    mst_owner = 1; mst_perr_drv_rd = 1; step();
    chk("R4 read path", 16'h0310);
    perr_resp_en = 0;
    cfg_wr_en = 1; cfg_be = 2'b11; cfg_wdata = 16'h0100; step();
    chk("R7 cfg clear", 16'h0210);
  endtask

  task automatic t_w0_and_lanes();
    ev_parity_det = 1; ev_tabort_sig = 1; step(); chk("R3 setup", 16'h8A10);
    lb_clear(2'b11, 16'h0000); step(); chk("R5 write zero", 16'h8A10);
    lb_clear(2'b01, 16'hFFFF); step(); chk("R6 low lane only", 16'h8A10);
    lb_clear(2'b10, 16'h8000); step(); chk("R6 high lane", 16'h0A10);
    lb_clear(2'b11, 16'hFFFF); step(); chk("R5 clear", 16'h0210);
  endtask

  task automatic t_ro_write();
    lb_clear(2'b11, 16'h06FF);
    cfg_wr_en = 1; cfg_be = 2'b11; cfg_wdata = 16'hFFFF; step();
    chk("R2 ro ignored", 16'h0210);
  endtask

  task automatic t_dual();
    ev_serr_drv = 1; ev_tabort_rcv = 1; step(); chk("R3 setup2", 16'h5210);
    lb_clear(2'b10, 16'h4000);
    cfg_wr_en = 1; cfg_be = 2'b10; cfg_wdata = 16'h1000; step();
    chk("R7 ORed clears", 16'h0210);
  endtask

  task automatic t_collision();
    ev_mabort_rcv = 1; lb_clear(2'b11, 16'h2000); step();
    chk("R8 set wins", 16'h2210);
    lb_clear(2'b11, 16'h2000); step(); chk("R5 clear after", 16'h0210);
  endtask

  task automatic t_host();
    ev_parity_det = 1; step(); chk("R9 setup", 16'h8210);
    host_mode = 1;
    {ev_parity_det, ev_serr_drv, ev_mabort_rcv, ev_tabort_rcv, ev_tabort_sig} = '1;
    perr_resp_en = 1; mst_owner = 1; mst_perr_drv_rd = 1; step();
    chk("R9 blocked", 16'h8210);
    lb_clear(2'b10, 16'h8000); step(); chk("R9 clear in host", 16'h0210);
    host_mode = 0; perr_resp_en = 0;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    t_reset();
    t_events();
    t_mdpe();
    t_w0_and_lanes();
    t_ro_write();
    t_dual();
    t_collision();
    t_host();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule